// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block collects a set of interrupt request lines, each tagged by configuration with one of three urgency levels (low, medium, high), plus a separate non-maskable request. Every cycle it picks the request that may be served now. It presents that request to the processor as an interrupt strobe, together with the word address of its vector and the level it was granted at.

The controller remembers which levels are in service. When the processor accepts an interrupt, the granted level is marked busy. When the processor signals a return from its handler, the most urgent busy level is released. A request is offered only if its level outranks every level already in service. A medium request can interrupt a low handler, and a high request can interrupt both. The non-maskable request outranks everything.

Among low sources the choice can be fixed (lowest index) or rotating, so that a low source that keeps requesting cannot starve the others. The vector table sits at address zero or at a relocated base.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While rst_n is low, irq_o is 0, vec_o is 0, lvl_o is 0 and active_o is 0.
- R2: Source s takes its level from lvl_cfg_i[2s+1:2s]: 0 is low, 1 is medium, 2 is high, and 3 means unassigned, so the source is never offered. lvl_en_i bit 0, 1 or 2 enables the low, medium or high level; a source at a disabled level is never offered.
- R3: Among the requests that are eligible, the order is non-maskable, then high, then medium, then low. Within the medium and high levels the lowest source index wins.
- R4: A request is offered only if its level is above every level marked in active_o. A medium request preempts a low handler and a high request preempts low and medium handlers. No request preempts a handler of the same level. A low request is offered only when no level is active.
- R5: The outputs are registered and reflect inputs and state one clock edge later. An ack_i seen while irq_o is 1 sets bit lvl_o of active_o at that edge (bit 0 low, 1 medium, 2 high, 3 non-maskable). An ack_i seen while irq_o is 0 has no effect.
- R6: reti_i clears the highest set bit of active_o. If ack_i and reti_i arrive in the same cycle, the clear acts on the previous active state, and then the acknowledged level is set.
- R7: nmi_i is served regardless of lvl_en_i, with lvl_o = 3 and vector offset 2. It is offered again only when active_o bit 3 is clear.
- R8: vec_o is the base plus VEC_STEP*(s+2) words for source s, and the base plus VEC_STEP for the non-maskable request. Word 0 is left to reset. The base is 0, or BOOT_BASE when boot_vec_i is 1. vec_o is 0 while irq_o is 0.
- R9: With rr_en_i at 0, the lowest-indexed pending low source wins.
- R10: With rr_en_i at 1, the low search starts just after the most recently acknowledged low source and wraps around. After reset the search starts at source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC | Request line per source |
| lvl_cfg_i | input | 2*NSRC | Two-bit level code per source |
| lvl_en_i | input | 3 | Enable for low, medium, high levels |
| rr_en_i | input | 1 | Rotating order for low sources |
| boot_vec_i | input | 1 | Relocate vector table to BOOT_BASE |
| nmi_i | input | 1 | Non-maskable request |
| ack_i | input | 1 | Processor accepts the offered interrupt |
| reti_i | input | 1 | Processor returns from a handler |
| irq_o | output | 1 | Interrupt offered to the processor |
| vec_o | output | VEC_W | Vector word address |
| lvl_o | output | 2 | Granted level (0 low, 1 medium, 2 high, 3 non-maskable) |
| active_o | output | 4 | In-service level bits |

## Verification
The return from one handler and the acceptance of a more urgent interrupt can fall on the same edge. The bench provokes this by starting a medium handler nested over a low one, offering a high request, and then pulsing ack_i and reti_i together. The medium bit must clear and the high bit must set, leaving only the low and high bits active, and no further offer may appear. An exhaustive sweep over all level codes, enable masks and request patterns for four sources judges the static ordering against an arithmetic model.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    LV_LOW  = 2'd0,
    LV_MED  = 2'd1,
    LV_HIGH = 2'd2,
    LV_NMI  = 2'd3
  } nic_lvl_e;

  localparam int unsigned NIC_NLVL = 4;
endpackage

// File: rtl/nic_pick.sv
// Finds the first set bit of pend_i scanning from start_i upward with wrap.
module nic_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend_i,
  input  logic [IW-1:0] start_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  int pos;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    pos   = 0;
    for (int k = 0; k < N; k++) begin
      pos = int'(start_i) + k;
      if (pos >= N) pos = pos - N;
      if (!hit_o && pend_i[pos]) begin
        hit_o = 1'b1;
        idx_o = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/nic_nest.sv
// In-service level tracking: a pop releases the top level, a push marks a level.
module nic_nest
  import nic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  nic_lvl_e            push_lvl_i,
  input  logic                pop_i,
  output logic [NIC_NLVL-1:0] active_q_o,
  output logic [NIC_NLVL-1:0] active_d_o
);
  logic [NIC_NLVL-1:0] active_q, active_d, top_mask, popped;

  always_comb begin
    top_mask = '0;
    for (int b = 0; b < NIC_NLVL; b++) begin
      if (active_q[b]) top_mask = NIC_NLVL'(1) << b;
    end
    popped   = pop_i ? (active_q & ~top_mask) : active_q;
    active_d = popped;
    if (push_i) active_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active_d;
  end

  assign active_q_o = active_q;
  assign active_d_o = active_d;

  AST_RETI_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && active_q != '0) |=>
      ($countones(active_q) == $countones($past(active_q)) - 1)); // R6
endmodule

// File: rtl/nic_vec.sv
// Vector word address: base plus slot times step; slot 1 is the non-maskable entry.
module nic_vec #(
  parameter int          IW        = 3,
  parameter int          VW        = 16,
  parameter int unsigned STEP      = 2,
  parameter int unsigned BOOT_BASE = 32'h1000
) (
  input  logic          take_i,
  input  logic          nmi_i,
  input  logic [IW-1:0] idx_i,
  input  logic          boot_i,
  output logic [VW-1:0] vec_o
);
  logic [VW-1:0] base, off;

  always_comb begin
    base  = boot_i ? VW'(BOOT_BASE) : '0;
    off   = nmi_i ? VW'(STEP) : VW'((int'(idx_i) + 2) * int'(STEP));
    vec_o = take_i ? (base + off) : '0;
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import nic_pkg::*;
#(
  parameter int          NSRC      = 8,
  parameter int          VEC_W     = 16,
  parameter int unsigned VEC_STEP  = 2,
  parameter int unsigned BOOT_BASE = 32'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [2*NSRC-1:0] lvl_cfg_i,
  input  logic [2:0]        lvl_en_i,
  input  logic              rr_en_i,
  input  logic              boot_vec_i,
  input  logic              nmi_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [1:0]        lvl_o,
  output logic [3:0]        active_o
);
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int NMSK = 3;

  // ---------------- per-level pending vectors ----------------
  logic [NMSK-1:0][NSRC-1:0] pend;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [1:0] code;
    assign code = lvl_cfg_i[2*s +: 2];
    for (genvar l = 0; l < NMSK; l++) begin : g_lvl
      assign pend[l][s] = req_i[s] && (code == 2'(l)) && lvl_en_i[l];
    end
  end

  // ---------------- state ----------------
  logic                irq_q, irq_d;
  nic_lvl_e            lvl_q, lvl_d;
  logic [IW-1:0]       idx_q, idx_d;
  logic [VEC_W-1:0]    vec_q, vec_d;
  logic [IW-1:0]       rr_last_q, rr_last_d;
  logic                rr_load;
  logic [IW-1:0]       rr_start;
  logic                ack_ok;
  logic [NIC_NLVL-1:0] active_q, active_d;

  assign ack_ok = ack_i && irq_q;

  // ---------------- pickers, one per maskable level ----------------
  logic [NMSK-1:0]          hit;
  logic [NMSK-1:0][IW-1:0]  idx;

  for (genvar l = 0; l < NMSK; l++) begin : g_pick
    logic [IW-1:0] st;
    if (l == 0) begin : g_rot
      assign st = rr_start;
    end else begin : g_fix
      assign st = '0;
    end
    nic_pick #(.N(NSRC), .IW(IW)) u_pick (
      .pend_i (pend[l]),
      .start_i(st),
      .hit_o  (hit[l]),
      .idx_o  (idx[l])
    );
  end

  // ---------------- nesting state ----------------
  nic_nest u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (ack_ok),
    .push_lvl_i(lvl_q),
    .pop_i     (reti_i),
    .active_q_o(active_q),
    .active_d_o(active_d)
  );

  // ---------------- low-level rotation pointer ----------------
  always_comb begin
    if (rr_en_i && (rr_last_q != IW'(NSRC - 1))) rr_start = rr_last_q + IW'(1);
    else                                         rr_start = '0;
    rr_load   = ack_ok && (lvl_q == LV_LOW);
    rr_last_d = rr_load ? idx_q : rr_last_q;
  end

  // ---------------- grant selection against next active state ----------------
  always_comb begin
    irq_d = 1'b0;
    lvl_d = LV_LOW;
    idx_d = '0;
    if (nmi_i && !active_d[3]) begin
      irq_d = 1'b1;
      lvl_d = LV_NMI;
    end else if (hit[2] && (active_d[3:2] == 2'b00)) begin
      irq_d = 1'b1;
      lvl_d = LV_HIGH;
      idx_d = idx[2];
    end else if (hit[1] && (active_d[3:1] == 3'b000)) begin
      irq_d = 1'b1;
      lvl_d = LV_MED;
      idx_d = idx[1];
    end else if (hit[0] && (active_d == '0)) begin
      irq_d = 1'b1;
      lvl_d = LV_LOW;
      idx_d = idx[0];
    end
  end

  nic_vec #(
    .IW       (IW),
    .VW       (VEC_W),
    .STEP     (VEC_STEP),
    .BOOT_BASE(BOOT_BASE)
  ) u_vec (
    .take_i(irq_d),
    .nmi_i (lvl_d == LV_NMI),
    .idx_i (idx_d),
    .boot_i(boot_vec_i),
    .vec_o (vec_d)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      lvl_q <= LV_LOW;
      idx_q <= '0;
      vec_q <= '0;
    end else begin
      irq_q <= irq_d;
      lvl_q <= lvl_d;
      idx_q <= idx_d;
      vec_q <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_last_q <= IW'(NSRC - 1);
    else if (rr_load) rr_last_q <= rr_last_d;
  end

  assign irq_o    = irq_q;
  assign vec_o    = vec_q;
  assign lvl_o    = lvl_q;
  assign active_o = active_q;

  // ---------------- assertions ----------------
  AST_GRANT_ABOVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ((active_q >> lvl_q) == 4'b0)); // R4

  AST_NMI_TAKES_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_i && !active_d[3]) |=> (irq_q && lvl_q == LV_NMI)); // R7

  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_q) |=> active_q[$past(lvl_q)]); // R5

  AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> (vec_q == '0)); // R8
endmodule

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  localparam int NS   = 4;
  localparam int VW   = 16;
  localparam int BOOT = 32'h100;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] req;
  logic [2*NS-1:0] cfg;
  logic [2:0]    en;
  logic          rr, boot, nmi, ack, reti;
  logic          irq_o;
  logic [VW-1:0] vec_o;
  logic [1:0]    lvl_o;
  logic [3:0]    active_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl #(.NSRC(NS), .VEC_W(VW), .VEC_STEP(2), .BOOT_BASE(BOOT)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_cfg_i(cfg), .lvl_en_i(en),
    .rr_en_i(rr), .boot_vec_i(boot), .nmi_i(nmi), .ack_i(ack), .reti_i(reti),
    .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o), .active_o(active_o)
  );

  function automatic int obs();
    return int'({irq_o, lvl_o, vec_o});
  endfunction

  function automatic int pack(int l, int v);
    return (1 << 18) | (l << 16) | v;
  endfunction

  function automatic int model(int c, int e, int r);
    for (int l = 2; l >= 0; l--) begin
      for (int i = 0; i < NS; i++) begin
        if (((r >> i) & 1) == 1 && ((c >> (2*i)) & 3) == l && ((e >> l) & 1) == 1)
          return pack(l, 2*(i+2));
      end
    end
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    chk("R1 reset outputs", obs(), 0);
    chk("R1 reset active", int'(active_o), 0);
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req = '0; cfg = '0; en = '0; rr = 0; boot = 0; nmi = 0; ack = 0; reti = 0;
    rst_n = 1'b0;
    #1;
    do_reset();

    // R2 R3 R9: sweep of all codes, enables and request patterns, nothing active
    for (int c = 0; c < 256; c++) begin
      for (int e = 0; e < 8; e++) begin
        for (int r = 0; r < 16; r++) begin
          cfg = 8'(c); en = 3'(e); req = 4'(r);
          step();
          chk("R2/R3/R9/R8 sweep", obs(), model(c, e, r));
        end
      end
    end

    // nesting walk: src0 low, src1 med, src2 high, src3 low
    cfg = 8'h24; en = 3'b111; req = 4'b0001;
    step();
    chk("R9 low offered", obs(), pack(0, 4));
    pulse_ack();
    chk("R5 low marked", int'(active_o), 1);
    chk("R4 low blocks low", obs(), 0);
    req = 4'b1011;
    step();
    chk("R4 medium preempts low", obs(), pack(1, 6));
    pulse_ack();
    chk("R5 medium marked", int'(active_o), 3);
    chk("R4 same level no preempt", obs(), 0);
    req = 4'b1111;
    step();
    chk("R4 high preempts medium", obs(), pack(2, 8));
    ack = 1'b1; reti = 1'b1; step(); ack = 1'b0; reti = 1'b0;
    chk("R6 ack and reti same edge", int'(active_o), 5);
    chk("R4 high active blocks all", obs(), 0);
    pulse_reti();
    chk("R6 reti pops high", int'(active_o), 1);
    chk("R3 high over medium", obs(), pack(2, 8));
    req = '0;
    pulse_reti();
    chk("R6 reti pops low", int'(active_o), 0);
    chk("R5 no request idle", obs(), 0);

    // non-maskable
    en = 3'b000; nmi = 1'b1;
    step();
    chk("R7 nmi ignores enables", obs(), pack(3, 2));
    pulse_ack();
    chk("R7 nmi marked", int'(active_o), 8);
    chk("R7 nmi not re-offered", obs(), 0);
    pulse_reti();
    chk("R7 nmi offered again", obs(), pack(3, 2));
    nmi = 1'b0;
    step();
    chk("R7 nmi withdrawn", obs(), 0);
    pulse_ack();
    chk("R5 ack without irq ignored", int'(active_o), 0);

    en = 3'b111; req = 4'b0100;
    step();
    pulse_ack();
    chk("R5 high marked", int'(active_o), 4);
    nmi = 1'b1;
    step();
    chk("R3 nmi preempts high", obs(), pack(3, 2));
    nmi = 1'b0; req = '0;
    pulse_reti();
    chk("R6 reti clears high", int'(active_o), 0);

    boot = 1'b1; req = 4'b0100;
    step();
    chk("R8 relocated vector", obs(), pack(2, BOOT + 8));
    nmi = 1'b1;
    step();
    chk("R8 relocated nmi vector", obs(), pack(3, BOOT + 2));
    nmi = 1'b0; boot = 1'b0; req = '0;
    step();

    // rotation among low sources
    do_reset();
    cfg = 8'h00; en = 3'b111; rr = 1'b1; req = 4'b1111;
    step();
    for (int k = 0; k < 5; k++) begin
      chk("R10 rotating order", obs(), pack(0, 2*((k % 4)+2)));
      pulse_ack();
      pulse_reti();
    end
    req = 4'b1001;
    step();
    chk("R10 wrap after last served", obs(), pack(0, 10));
    rr = 1'b0;
    step();
    chk("R9 fixed order restored", obs(), pack(0, 4));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule